// File: doc/BRIEF.md
# Multi-Core Barrier Counter with Wake Pulse

This block is an APB3 slave that lets a group of cores meet at a barrier. Each core writes once to an arrival register when it reaches the barrier, and then sleeps. An internal counter tracks how many cores have arrived and compares that number with a target level that software can program.

When the arrival that completes the group is written, the counter returns to zero. In the same update, a wake output goes high for exactly one clock cycle so that every sleeping core can resume. The target level defaults to four after reset. Software can read it back, and it can also read the current arrival count.

Register offsets, as byte addresses in the peripheral window: 0x0 is the arrival count (read-only), 0x8 is the arrival register (write-only), and 0xC is the target level (read/write). Any other offset reads as zero, and writes to it are dropped.

Top module: `barrier_sync_apb`

## Requirements
- R1: After reset the arrival count reads 0 at offset 0x0, the level reads 4 at offset 0xC, and the wake output is low.
- R2: Each completed APB write to offset 0x8 raises the arrival count by one, whatever the write data is.
- R3: When an arrival write makes the count equal the effective level, the count reads 0 afterwards. The wake output is high in the cycle that follows that write's access phase and in no other cycle.
- R4: The wake output is never high in two consecutive cycles.
- R5: A write to offset 0xC loads all 32 data bits into the level, and a read of 0xC returns the stored value unchanged.
- R6: A write to offset 0xC clears the arrival count to 0 without raising the wake output.
- R7: A stored level of 0 behaves as a level of 1, so every arrival raises the wake output and the count stays at 0.
- R8: An arrival write counts only in its access phase (PSEL and PENABLE both high, PWRITE high). A setup phase alone, or a read of offset 0x8, leaves the count unchanged.
- R9: Offset 0x0 returns the arrival count, zero-extended to 32 bits. Writes to 0x0 leave the count unchanged.
- R10: PREADY is always high and PSLVERR is always low.
- R11: Reads of offset 0x8 and of any unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write strobe, high for writes |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | APB ready, tied high |
| pslverr | output | 1 | APB error, tied low |
| wake | output | 1 | One-cycle pulse when the barrier completes |

## Verification
The bench checks the wake output in every cycle, not only after arrivals. A design that fires one arrival early or late, holds the pulse for two cycles, or pulses when the level is rewritten is therefore caught at the cycle where it goes wrong.

Several corner cases are targeted directly:
- A level of 0. A design that compares against the raw value would never wake, and its count would run up unbounded.
- A level rewrite in the middle of a barrier. A design that keeps the partial count would wake too early.
- A setup phase with no access phase, and a read of the arrival register. A design that decodes on PSEL alone, or ignores PWRITE, would count arrivals that never happened.
- Arrival data of all ones. A design that adds the data instead of one would show a wrong count.

// File: rtl/barrier_pkg.sv
// Shared constants and types for the barrier counter.
// Assumes byte addressing, with registers on 32-bit word offsets.
package barrier_pkg;

    localparam int unsigned OFS_COUNT  = 32'h0;
    localparam int unsigned OFS_ARRIVE = 32'h8;
    localparam int unsigned OFS_LEVEL  = 32'hC;

    typedef enum logic [1:0] {
        RSEL_NONE   = 2'd0,
        RSEL_COUNT  = 2'd1,
        RSEL_LEVEL  = 2'd2
    } rsel_e;

endpackage

// File: rtl/barrier_apb_decode.sv
// APB address decoder for the barrier counter.
// Turns an APB transfer into one-cycle write strobes, which fire in the
// access phase only, and into a read selector for the data mux.
// Assumes PREADY is held high, so every access phase lasts one cycle.
module barrier_apb_decode
    import barrier_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output logic              arrive_we,
    output logic              level_we,
    output rsel_e             rd_sel
);

    localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
    localparam logic [ADDR_W-1:0] A_ARRIVE = ADDR_W'(OFS_ARRIVE);
    localparam logic [ADDR_W-1:0] A_LEVEL  = ADDR_W'(OFS_LEVEL);

    logic access_wr;

    // Write strobes: qualified by select, enable and direction.
    always_comb begin
        access_wr = psel && penable && pwrite;
        arrive_we = access_wr && (paddr == A_ARRIVE);
        level_we  = access_wr && (paddr == A_LEVEL);
    end

    // Read selector: which register drives the read data.
    always_comb begin
        if (paddr == A_COUNT)      rd_sel = RSEL_COUNT;
        else if (paddr == A_LEVEL) rd_sel = RSEL_LEVEL;
        else                       rd_sel = RSEL_NONE;
    end

endmodule

// File: rtl/barrier_level_reg.sv
// Target level register.
// Holds the programmed level and derives the effective level used by the
// comparator, where a stored zero counts as one.
module barrier_level_reg #(
    parameter int              DATA_W      = 32,
    parameter logic [DATA_W-1:0] LEVEL_RESET = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              level_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] level,
    output logic [DATA_W-1:0] eff_level
);

    // Level storage: reset default, loaded on a level write.
    always_ff @(posedge clk) begin
        if (!rst_n)        level <= LEVEL_RESET;
        else if (level_we) level <= wdata;
    end

    // Effective level: zero is raised to one.
    always_comb begin
        eff_level = (level == '0) ? DATA_W'(1) : level;
    end

    // The stored level follows the write data, and only on a level write.
    p_level_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        level_we |=> level == $past(wdata));
    p_level_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !level_we |=> $stable(level));

endmodule

// File: rtl/barrier_arrival_ctr.sv
// Arrival counter and wake generator.
// Counts arrival strobes. When the incremented value equals the effective
// level, it clears the count and raises wake for one cycle. A level write
// clears the count. Assumes arrive and clear are never high together.
module barrier_arrival_ctr #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arrive,
    input  logic              clear,
    input  logic [DATA_W-1:0] eff_level,
    output logic [DATA_W-1:0] count,
    output logic              wake
);

    logic [DATA_W-1:0] count_inc;
    logic              hit;

    // Compare the post-increment value with the level.
    always_comb begin
        count_inc = count + DATA_W'(1);
        hit       = arrive && (count_inc == eff_level);
    end

    // Count update: clear on a hit or a level write, step on an arrival.
    always_ff @(posedge clk) begin
        if (!rst_n)             count <= '0;
        else if (clear || hit)  count <= '0;
        else if (arrive)        count <= count_inc;
    end

    // Wake flop: one cycle high, in the cycle after the completing arrival.
    always_ff @(posedge clk) begin
        if (!rst_n) wake <= 1'b0;
        else        wake <= hit;
    end

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (arrive && !hit) |=> count == $past(count) + DATA_W'(1));
    p_clear_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (count == '0) && wake);
    p_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake);
    p_level_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0) && !wake);
    p_level_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (arrive && eff_level == DATA_W'(1)) |=> wake && count == '0);
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!arrive && !clear) |=> $stable(count) && !wake);

endmodule

// File: rtl/barrier_sync_apb.sv
// APB3 barrier counter, top level.
// Connects the decoder, the level register and the arrival counter, and
// drives the read mux. Transfers never stall and never report an error.
module barrier_sync_apb
    import barrier_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 32,
    parameter int LEVEL_RESET = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    output logic              wake
);

    logic              arrive_we;
    logic              level_we;
    rsel_e             rd_sel;
    logic [DATA_W-1:0] level;
    logic [DATA_W-1:0] eff_level;
    logic [DATA_W-1:0] count;

    barrier_apb_decode #(.ADDR_W(ADDR_W)) u_decode (
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .arrive_we (arrive_we),
        .level_we  (level_we),
        .rd_sel    (rd_sel)
    );

    barrier_level_reg #(
        .DATA_W      (DATA_W),
        .LEVEL_RESET (DATA_W'(LEVEL_RESET))
    ) u_level (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_we  (level_we),
        .wdata     (pwdata),
        .level     (level),
        .eff_level (eff_level)
    );

    barrier_arrival_ctr #(.DATA_W(DATA_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .arrive    (arrive_we),
        .clear     (level_we),
        .eff_level (eff_level),
        .count     (count),
        .wake      (wake)
    );

    // Read mux: the count, the level, or zero.
    always_comb begin
        case (rd_sel)
            RSEL_COUNT: prdata = count;
            RSEL_LEVEL: prdata = level;
            default:    prdata = '0;
        endcase
    end

    // Handshake: zero wait states, no error response.
    always_comb begin
        pready  = 1'b1;
        pslverr = 1'b0;
    end

    p_handshake_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pready && !pslverr);
    p_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == RSEL_NONE) |-> prdata == '0);

endmodule

// File: tb/barrier_sync_apb_bench.sv
// Scoreboard bench for barrier_sync_apb.
// The driver tasks keep a reference model of the count and the level. Each
// read pushes the value the model predicts into a queue, and the monitor
// pops and compares it in the access phase. The monitor also compares the
// wake output with the driver's expectation in every cycle.
`timescale 1ns/1ps
module barrier_sync_apb_bench;

    localparam int AW = 12;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          psel = 1'b0;
    logic          penable = 1'b0;
    logic          pwrite = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [DW-1:0] pwdata = '0;
    logic [DW-1:0] prdata;
    logic          pready;
    logic          pslverr;
    logic          wake;

    int total = 0;
    int bad = 0;
    logic mon_on = 1'b0;
    logic exp_wake = 1'b0;
    logic [DW-1:0] m_cnt = '0;
    logic [DW-1:0] m_lvl = 32'd4;
    logic [DW-1:0] q_val[$];
    string         q_tag[$];

    always #2.5 clk = ~clk;

    barrier_sync_apb u_barrier_sync_apb (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .wake(wake)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Write, with an optional setup-only transfer that never reaches access.
    task automatic apb_wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input bit do_access);
        logic fire;
        logic [DW-1:0] eff;
        fire = 1'b0;
        @(posedge clk); #1;
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(posedge clk); #1;
        if (do_access) penable = 1'b1;
        else psel = 1'b0;
        if (do_access) begin
            if (a == AW'(8)) begin
                eff = (m_lvl == '0) ? 32'd1 : m_lvl;
                m_cnt = m_cnt + 1;
                if (m_cnt == eff) begin m_cnt = '0; fire = 1'b1; end
            end else if (a == AW'(12)) begin
                m_lvl = d; m_cnt = '0;
            end
            @(posedge clk); #1;
            psel = 1'b0; penable = 1'b0;
            exp_wake = fire;
            @(posedge clk); #1;
            exp_wake = 1'b0;
        end
    endtask

    // Read: push the predicted value, then run the transfer.
    task automatic apb_rd(input logic [AW-1:0] a, input string tag);
        logic [DW-1:0] e;
        if (a == AW'(0))       e = m_cnt;
        else if (a == AW'(12)) e = m_lvl;
        else                   e = '0;
        q_val.push_back(e);
        q_tag.push_back(tag);
        @(posedge clk); #1;
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(posedge clk); #1;
        penable = 1'b1;
        @(posedge clk); #1;
        psel = 1'b0; penable = 1'b0;
    endtask

    // Monitor: read data in the access phase, wake and handshake every cycle.
    always @(negedge clk) begin
        if (mon_on) begin
            if (psel && penable && !pwrite) begin
                if (q_val.size() == 0) check(1'b0, "R11 unexpected read", prdata, '0);
                else begin
                    logic [DW-1:0] e;
                    string t;
                    e = q_val.pop_front();
                    t = q_tag.pop_front();
                    check(prdata === e, t, prdata, e);
                end
            end
            if (wake !== exp_wake)
                check(1'b0, "R3/R4 wake", {31'd0, wake}, {31'd0, exp_wake});
            if (!(pready === 1'b1 && pslverr === 1'b0))
                check(1'b0, "R10 handshake", {30'd0, pready, pslverr}, 32'd2);
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        mon_on = 1'b1;
        // R1 reset state
        check(wake === 1'b0, "R1 wake after reset", {31'd0, wake}, '0);
        apb_rd(12'h0, "R1 count after reset");
        apb_rd(12'hC, "R1 level after reset");
        // R11 the arrival register and unmapped offsets read zero
        apb_rd(12'h8, "R11 arrival reads zero");
        apb_rd(12'h10, "R11 unmapped reads zero");
        // R10 handshake
        check(pready === 1'b1 && pslverr === 1'b0, "R10 handshake",
              {30'd0, pready, pslverr}, 32'd2);
        // R2 arrivals count, whatever the data
        apb_wr(12'h8, 32'h0, 1'b1);        apb_rd(12'h0, "R2 one arrival");
        apb_wr(12'h8, 32'hFFFF_FFFF, 1'b1); apb_rd(12'h0, "R2 all-ones data");
        apb_wr(12'h8, 32'h5A, 1'b1);       apb_rd(12'h0, "R2 three arrivals");
        // R3 the fourth arrival wakes and clears
        apb_wr(12'h8, 32'h1, 1'b1);        apb_rd(12'h0, "R3 cleared at level");
        // R5 program level 2, read it back
        apb_wr(12'hC, 32'd2, 1'b1);        apb_rd(12'hC, "R5 level readback");
        // R6 partial barrier discarded on a level write
        apb_wr(12'h8, 32'h0, 1'b1);        apb_rd(12'h0, "R6 partial count");
        apb_wr(12'hC, 32'd3, 1'b1);        apb_rd(12'h0, "R6 cleared by level write");
        for (int i = 0; i < 3; i++) apb_wr(12'h8, 32'h0, 1'b1);
        apb_rd(12'h0, "R3 level 3 completed");
        // R7 level zero behaves as one
        apb_wr(12'hC, 32'd0, 1'b1);        apb_rd(12'hC, "R7 level zero stored");
        for (int i = 0; i < 3; i++) begin
            apb_wr(12'h8, 32'h0, 1'b1);
            apb_rd(12'h0, "R7 count stays zero");
        end
        // R8 a setup phase alone, or a read of 0x8, does not count
        apb_wr(12'hC, 32'd5, 1'b1);
        apb_wr(12'h8, 32'h0, 1'b1);
        apb_wr(12'h8, 32'h0, 1'b0);        apb_rd(12'h0, "R8 setup-only ignored");
        apb_rd(12'h8, "R8 read of arrival");
        apb_rd(12'h0, "R8 read did not count");
        // R9 writes to the count offset are ignored
        apb_wr(12'h0, 32'h7, 1'b1);        apb_rd(12'h0, "R9 count write ignored");
        // R5 full-width level, then a long run of arrivals
        apb_wr(12'hC, 32'h8000_0001, 1'b1); apb_rd(12'hC, "R5 wide level");
        for (int i = 0; i < 10; i++) apb_wr(12'h8, 32'(i), 1'b1);
        apb_rd(12'h0, "R2 ten arrivals");
        repeat (4) @(posedge clk);
        #1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule